// File: doc/BRIEF.md
# TDM Bit Clock and Frame Sync Generator

This block derives a TDM serial bit clock from a fast system clock with a fractional phase accumulator, and frames that clock into slots of eight bits with a programmable frame sync pulse. A frame is a configured count of 8-bit slots, optionally led by one extra frame bit. Every half period of the bit clock is one unit of the frame position counter, and the frame sync pulse length and placement are both set in those half-period units.

A serialiser next to the block uses the bit strobe and frame strobe to load and shift data. When the block is disabled, or when the accumulator increment is zero, it stops generating. The bit clock and frame sync outputs then follow the externally received clock and sync inputs, so an outside master can time the interface.

Configuration inputs are expected to stay stable while the generator runs. The slot count must be at least one, and the sync offset must be less than the frame length in half periods.

Top module: `tdm_clkgen`

## Requirements
- R1: Each carry out of the most significant bit of the 32-bit accumulator (acc + incr) is one half period of the bit clock. With incr = 0x8000_0000 the bit clock output changes every 2 system clocks, and with incr = 0x4000_0000 it changes every 4.
- R2: The bit length code sets how many bit clock periods make one bit time: 1 for code 0, 2 for code 1, 4 for code 2. Code 3 behaves like code 2.
- R3: A frame holds num_slots x 8 bit times, plus one more when extra_bit is 1. frame_stb pulses for one cycle at the start of each frame, so the frame period is that bit count x bit time.
- R4: bit_stb pulses for one cycle at the start of every bit time, the frame bit included. Every frame_stb cycle also carries bit_stb.
- R5: Frame sync is asserted for fs_len half bit-clock periods per frame. With fs_len = 0 it is never asserted.
- R6: Frame sync assertion begins fs_loc half periods before bit 0 of slot 0, and wraps into the previous frame when needed. With extra_bit = 1, bit 0 of slot 0 is one bit time after the frame start.
- R7: With bclk_pol = 0 the bit clock is high in the first half of each of its periods, so a rising edge starts a bit. With bclk_pol = 1 it is inverted. With fs_pol = 0 frame sync is active high, and with fs_pol = 1 it is active low.
- R8: While enable is 0 or incr is 0, gen_active is 0, bclk_o equals ext_bclk, fsync_o equals ext_fsync, and both strobes are 0.
- R9: In the first cycle in which gen_active is 1, the frame starts at slot 0, bit 0, and frame_stb and bit_stb are both 1.
- R10: After reset, gen_active, bit_stb and frame_stb are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the generator |
| incr | input | 32 | Accumulator increment; 0 selects external clocking |
| num_slots | input | 10 | Count of 8-bit slots per frame |
| extra_bit | input | 1 | Add a leading frame bit |
| bit_len | input | 2 | Bit clocks per bit time code |
| fs_loc | input | 5 | Sync start, in half periods before slot 0 bit 0 |
| fs_len | input | 5 | Sync length in half periods |
| bclk_pol | input | 1 | Bit clock polarity select |
| fs_pol | input | 1 | Frame sync polarity select |
| ext_bclk | input | 1 | Received bit clock |
| ext_fsync | input | 1 | Received frame sync |
| bclk_o | output | 1 | Bit clock |
| fsync_o | output | 1 | Frame sync |
| bit_stb | output | 1 | Start-of-bit strobe |
| frame_stb | output | 1 | Start-of-frame strobe |
| gen_active | output | 1 | Generator is driving clock and sync |

## Verification
A wrong frame position shows within one frame: the spacing of frame_stb changes, the number of bit strobes between two frame strobes changes, or the sync pulse moves relative to the frame strobe. A wrong accumulator shows within a few bit clock edges as a changed toggle rate on bclk_o. A wrong start or handover state shows in the first cycle, as missing strobes when generation begins or as outputs that do not follow the external inputs when it stops. Each scenario measures a full steady-state frame after start-up, so an offset error of a single half period is visible.

// File: rtl/tdm_clkgen_pkg.sv
package tdm_clkgen_pkg;

   typedef enum logic [1:0] {
      BL_ONE  = 2'd0,
      BL_TWO  = 2'd1,
      BL_FOUR = 2'd2,
      BL_RSV  = 2'd3
   } bitlen_e;

   // log2 of the half bit-clock periods in one bit time (R2: code 3 acts as code 2)
   function automatic logic [1:0] halves_log2(input logic [1:0] code);
      case (bitlen_e'(code))
         BL_ONE:  return 2'd1;
         BL_TWO:  return 2'd2;
         default: return 2'd3;
      endcase
   endfunction

endpackage

// File: rtl/tdm_nco.sv
module tdm_nco #(
   parameter int ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [ACC_W-1:0] incr,
   output logic             tick
);
   if (ACC_W < 8) begin : g_bad_width
      $error("tdm_nco: ACC_W must be at least 8");
   end

   logic [ACC_W-1:0] acc;
   logic [ACC_W:0]   sum;

   assign sum  = {1'b0, acc} + {1'b0, incr};
   assign tick = run & sum[ACC_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   acc <= '0;
      else if (!run) acc <= '0;
      else          acc <= sum[ACC_W-1:0];
   end
endmodule

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
   import tdm_clkgen_pkg::*;
#(
   parameter int SLOT_W = 10,
   parameter int POS_W  = SLOT_W + 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              run,
   input  logic              tick,
   input  logic [SLOT_W-1:0] num_slots,
   input  logic              extra_bit,
   input  logic [1:0]        bit_len,
   output logic [POS_W-1:0]  pos,
   output logic [POS_W-1:0]  frame_len,
   output logic              bit_stb,
   output logic              frame_stb
);
   if (POS_W < SLOT_W + 7) begin : g_bad_pos
      $error("tdm_frame_timer: POS_W too small for the longest frame");
   end

   logic [1:0]       hs;
   logic [POS_W-1:0] n_bits;
   logic [POS_W-1:0] bit_mask;
   logic [POS_W-1:0] pos_nxt;
   logic             aligned;

   assign hs        = halves_log2(bit_len);
   assign n_bits    = (POS_W'(num_slots) << 3) + POS_W'(extra_bit);
   assign frame_len = n_bits << hs;
   assign bit_mask  = (POS_W'(1) << hs) - POS_W'(1);
   assign pos_nxt   = (pos == frame_len - POS_W'(1)) ? '0 : pos + POS_W'(1);
   assign aligned   = (pos_nxt & bit_mask) == '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos       <= '0;
         bit_stb   <= 1'b0;
         frame_stb <= 1'b0;
      end else if (!go) begin
         pos       <= '0;
         bit_stb   <= 1'b0;
         frame_stb <= 1'b0;
      end else if (!run) begin
         pos       <= '0;
         bit_stb   <= 1'b1;
         frame_stb <= 1'b1;
      end else if (tick) begin
         pos       <= pos_nxt;
         bit_stb   <= aligned;
         frame_stb <= (pos_nxt == '0);
      end else begin
         bit_stb   <= 1'b0;
         frame_stb <= 1'b0;
      end
   end

   // R1: position only moves on an accumulator carry
   p_hold_without_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && !$past(tick)) |-> $stable(pos));

   // R9: generation begins at frame position zero with both strobes
   p_start_at_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !$past(run)) |-> (pos == '0 && frame_stb && bit_stb));

   // R4: a frame start is always a bit start
   p_frame_is_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      frame_stb |-> bit_stb);
endmodule

// File: rtl/tdm_fsync_shaper.sv
module tdm_fsync_shaper
   import tdm_clkgen_pkg::*;
#(
   parameter int POS_W = 17,
   parameter int FS_W  = 5
) (
   input  logic [POS_W-1:0] pos,
   input  logic [POS_W-1:0] frame_len,
   input  logic             extra_bit,
   input  logic [1:0]       bit_len,
   input  logic [FS_W-1:0]  fs_loc,
   input  logic [FS_W-1:0]  fs_len,
   output logic             hit
);
   localparam int W = POS_W + 1;

   logic [W-1:0] fl, p0, tmp, start, d, pw;

   assign fl    = {1'b0, frame_len};
   assign pw    = {1'b0, pos};
   assign p0    = extra_bit ? (W'(1) << halves_log2(bit_len)) : '0;
   assign tmp   = p0 + fl - W'(fs_loc);
   assign start = (tmp >= fl) ? tmp - fl : tmp;
   assign d     = (pw >= start) ? pw - start : pw + fl - start;
   assign hit   = d < W'(fs_len);
endmodule

// File: rtl/tdm_clkgen.sv
module tdm_clkgen #(
   parameter int ACC_W  = 32,
   parameter int SLOT_W = 10,
   parameter int FS_W   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [ACC_W-1:0]  incr,
   input  logic [SLOT_W-1:0] num_slots,
   input  logic              extra_bit,
   input  logic [1:0]        bit_len,
   input  logic [FS_W-1:0]   fs_loc,
   input  logic [FS_W-1:0]   fs_len,
   input  logic              bclk_pol,
   input  logic              fs_pol,
   input  logic              ext_bclk,
   input  logic              ext_fsync,
   output logic              bclk_o,
   output logic              fsync_o,
   output logic              bit_stb,
   output logic              frame_stb,
   output logic              gen_active
);
   localparam int POS_W = SLOT_W + 7;

   if (SLOT_W < 1 || SLOT_W > 16) begin : g_bad_slot
      $error("tdm_clkgen: SLOT_W out of range");
   end
   if (FS_W < 1 || FS_W > POS_W) begin : g_bad_fs
      $error("tdm_clkgen: FS_W out of range");
   end

   logic             go, run, tick, fs_hit;
   logic [POS_W-1:0] pos, frame_len;

   assign go = enable && (incr != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run <= 1'b0;
      else        run <= go;
   end

   tdm_nco #(.ACC_W(ACC_W)) u_nco (
      .clk(clk), .rst_n(rst_n), .run(run), .incr(incr), .tick(tick)
   );

   tdm_frame_timer #(.SLOT_W(SLOT_W), .POS_W(POS_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .go(go), .run(run), .tick(tick),
      .num_slots(num_slots), .extra_bit(extra_bit), .bit_len(bit_len),
      .pos(pos), .frame_len(frame_len), .bit_stb(bit_stb), .frame_stb(frame_stb)
   );

   tdm_fsync_shaper #(.POS_W(POS_W), .FS_W(FS_W)) u_fsync (
      .pos(pos), .frame_len(frame_len), .extra_bit(extra_bit), .bit_len(bit_len),
      .fs_loc(fs_loc), .fs_len(fs_len), .hit(fs_hit)
   );

   assign gen_active = run;
   assign bclk_o     = run ? (~pos[0] ^ bclk_pol) : ext_bclk;
   assign fsync_o    = run ? (fs_hit ^ fs_pol) : ext_fsync;

   // R8: stopped generator hands both lines to the external sources
   p_passthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (bclk_o == ext_bclk && fsync_o == ext_fsync && !bit_stb && !frame_stb));

   // R5: zero length means the sync line stays at its idle level
   p_fs_zero_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && fs_len == '0) |-> (fsync_o == fs_pol));
endmodule

// File: tb/tdm_clkgen_tb.sv
module tdm_clkgen_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic [31:0] incr = 32'h8000_0000;
   logic [9:0]  num_slots = 10'd2;
   logic        extra_bit = 1'b0;
   logic [1:0]  bit_len = 2'd0;
   logic [4:0]  fs_loc = 5'd0;
   logic [4:0]  fs_len = 5'd1;
   logic        bclk_pol = 1'b0;
   logic        fs_pol = 1'b0;
   logic        ext_bclk = 1'b0;
   logic        ext_fsync = 1'b0;
   logic        bclk_o, fsync_o, bit_stb, frame_stb, gen_active;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   tdm_clkgen u_dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .incr(incr),
      .num_slots(num_slots), .extra_bit(extra_bit), .bit_len(bit_len),
      .fs_loc(fs_loc), .fs_len(fs_len), .bclk_pol(bclk_pol), .fs_pol(fs_pol),
      .ext_bclk(ext_bclk), .ext_fsync(ext_fsync), .bclk_o(bclk_o),
      .fsync_o(fsync_o), .bit_stb(bit_stb), .frame_stb(frame_stb),
      .gen_active(gen_active)
   );

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Run one configuration and measure the frame between the 2nd and 3rd frame strobes.
   task automatic run_frame(input int ns, input bit ex, input int bl, input int loc,
                            input int len, input bit fpol, input bit bpol,
                            output int period, output int bits, output int high,
                            output int rise, output int bclk_at);
      int nstb = 0, s2 = 0, s3 = 0, last_rise = -1;
      bit prev_as = 1'b0, as_now, fin = 1'b0;
      enable = 1'b0;
      @(negedge clk);
      incr = 32'h8000_0000; num_slots = 10'(ns); extra_bit = ex; bit_len = 2'(bl);
      fs_loc = 5'(loc); fs_len = 5'(len); fs_pol = fpol; bclk_pol = bpol;
      @(negedge clk);
      enable = 1'b1;
      bits = 0; high = 0; bclk_at = 0;
      for (int cyc = 0; cyc < 4000 && !fin; cyc++) begin
         @(negedge clk);
         as_now = fsync_o ^ fpol;
         if (as_now && !prev_as) last_rise = cyc;
         prev_as = as_now;
         if (frame_stb) begin
            nstb++;
            if (nstb == 2) s2 = cyc;
            if (nstb == 3) begin
               s3 = cyc; bclk_at = int'(bclk_o); fin = 1'b1;
            end
         end
         if (nstb == 2) begin
            bits += int'(bit_stb);
            high += int'(as_now);
         end
      end
      period = s3 - s2;
      rise   = (last_rise < 0) ? -1 : s3 - last_rise;
      enable = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R10 gen_active after reset", int'(gen_active), 0);
      check("R10 bit_stb after reset", int'(bit_stb), 0);
      check("R10 frame_stb after reset", int'(frame_stb), 0);
   endtask

   task automatic t_rate(input logic [31:0] inc, input int exp_toggles);
      logic prev;
      int tog = 0;
      enable = 1'b0; num_slots = 10'd2; bit_len = 2'd0; extra_bit = 1'b0;
      @(negedge clk);
      incr = inc; enable = 1'b1;
      repeat (10) @(negedge clk);
      prev = bclk_o;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (bclk_o != prev) tog++;
         prev = bclk_o;
      end
      check("R1 bit clock toggles in 200 cycles", tog, exp_toggles);
      enable = 1'b0;
   endtask

   task automatic t_frame(input int ns, input bit ex, input int bl, input int exp_period,
                          input int exp_bits);
      int p, b, h, r, bc;
      run_frame(ns, ex, bl, 0, 1, 1'b0, 1'b0, p, b, h, r, bc);
      check("R2/R3 frame period in cycles", p, exp_period);
      check("R4 bit strobes per frame", b, exp_bits);
   endtask

   task automatic t_fsync(input int ns, input bit ex, input int bl, input int loc,
                          input int len, input bit fpol, input bit bpol,
                          input int exp_high, input int exp_rise);
      int p, b, h, r, bc;
      run_frame(ns, ex, bl, loc, len, fpol, bpol, p, b, h, r, bc);
      check("R5 sync asserted cycles per frame", h, exp_high);
      if (exp_rise >= 0) check("R6 sync rise to frame start distance", r, exp_rise);
      check("R7 bit clock level at frame start", bc, bpol ? 0 : 1);
   endtask

   task automatic t_handover();
      enable = 1'b1; incr = 32'h0;
      repeat (2) @(negedge clk);
      check("R8 gen_active with zero incr", int'(gen_active), 0);
      ext_bclk = 1'b1; ext_fsync = 1'b0; #1;
      check("R8 bclk_o follows ext_bclk", int'(bclk_o), 1);
      check("R8 fsync_o follows ext_fsync", int'(fsync_o), 0);
      ext_bclk = 1'b0; ext_fsync = 1'b1; #1;
      check("R8 bclk_o follows ext_bclk low", int'(bclk_o), 0);
      check("R8 fsync_o follows ext_fsync high", int'(fsync_o), 1);
      check("R8 strobes quiet", int'(bit_stb | frame_stb), 0);
      enable = 1'b0; incr = 32'h8000_0000;
      repeat (2) @(negedge clk);
      check("R8 gen_active with enable low", int'(gen_active), 0);
   endtask

   task automatic t_start();
      @(negedge clk);
      enable = 1'b1;
      @(negedge clk);
      check("R9 gen_active on first cycle", int'(gen_active), 1);
      check("R9 frame_stb on first cycle", int'(frame_stb), 1);
      check("R9 bit_stb on first cycle", int'(bit_stb), 1);
      @(negedge clk);
      check("R9 frame_stb single cycle", int'(frame_stb), 0);
      enable = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_rate(32'h8000_0000, 100);
      t_rate(32'h4000_0000, 50);
      t_frame(2, 1'b0, 0, 64, 16);
      t_frame(2, 1'b1, 0, 68, 17);
      t_frame(3, 1'b0, 1, 192, 24);
      t_frame(1, 1'b0, 2, 128, 8);
      t_frame(1, 1'b0, 3, 128, 8);
      t_fsync(2, 1'b0, 0, 2, 3, 1'b0, 1'b0, 6, 4);
      t_fsync(2, 1'b1, 0, 5, 4, 1'b0, 1'b0, 8, 6);
      t_fsync(2, 1'b0, 0, 3, 0, 1'b0, 1'b0, 0, -1);
      t_fsync(2, 1'b0, 0, 0, 1, 1'b1, 1'b1, 2, 0);
      t_fsync(1, 1'b1, 1, 1, 2, 1'b0, 1'b0, 4, 66);
      t_handover();
      t_start();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end
endmodule